// File: doc/BRIEF.md
# Constant Unsigned Divider by Multiply-Add

This block divides an unsigned N-bit operand by a divisor fixed at elaboration time, with no iterative hardware. The quotient comes from one multiply and one add followed by a free right shift: q = (A*x + B) >> K. Package functions compute K, A and B while the design elaborates, from the divisor, the operand width and a rounding-mode parameter. They search upward for the smallest shift K that admits a valid multiplier. For each K they try the multiplier just above and just below 2^K/D. From the range of addends that keeps every operand correctly rounded, they take the value with the fewest set bits.

Three rounding behaviours are available: truncation toward zero, nearest (ties cannot occur because the divisor is odd), and faithful (either neighbour of the true quotient, but exact whenever the divisor divides the operand). The divisor must be odd and at least 3. The quotient port is exactly wide enough for the largest quotient the chosen mode can produce. A parameter places a synchronous register on the quotient, or leaves the path purely combinational.

Top module: `cdiv_const`

## Requirements
- R1: With MODE = RND_TRUNC (encoding 0), q_o equals floor(x/D) for every x in [0, 2^N-1].
- R2: With MODE = RND_NEAREST (encoding 1), q_o equals floor((2x + D) / (2D)), the nearest integer to x/D, for every x.
- R3: With MODE = RND_FAITHFUL (encoding 2), q_o equals floor(x/D) or floor(x/D)+1, so it differs from x/D by less than one.
- R4: In every mode, when D divides x, q_o equals x/D exactly.
- R5: x = 0 gives q_o = 0. The largest operand 2^N-1 gives the mode's largest quotient with no bits lost. The port width is ceil(log2(Qmax+1)), where Qmax is that largest quotient.
- R6: With OUT_REG = 1, q_o shows the quotient of the operand present at the previous rising clock edge, and a rising edge with rst_n low sets q_o to 0. With OUT_REG = 0, q_o follows x_i with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional quotient register |
| rst_n | input | 1 | Synchronous active-low reset of the quotient register |
| x_i | input | N | Unsigned dividend |
| q_o | output | ceil(log2(Qmax+1)) | Rounded quotient |

## Verification
The bench sweeps every operand of five configurations. These mix small and large divisors, all three modes and both output variants. The sweep reaches the remainders where a constant that is one too small or too large first goes wrong, usually near the top of the range, where the error in A*x grows largest. A wrong addend shows up as an off-by-one at exact multiples (R4) or at x = 0. A wrong nearest bias shows up at remainders next to D/2. A truncated port or product loses the top quotients at x = 2^N-1. The bench also checks the registered variant mid-cycle for its one-clock latency, and resets it in the middle of the sweep.

// File: rtl/cdiv_pkg.sv
// Package: rounding modes and elaboration-time derivation of the
// multiply-add constants (shift K, multiplier A, addend B).
// Assumes the divisor is odd and at least 3, and that N + K stays below 62.
package cdiv_pkg;

    typedef enum logic [1:0] {
        RND_TRUNC    = 2'd0,
        RND_NEAREST  = 2'd1,
        RND_FAITHFUL = 2'd2
    } rnd_mode_t;

    typedef struct packed {
        logic   ok;
        longint lo;
        longint hi;
    } b_span_t;

    typedef struct packed {
        int     k;
        longint a;
        longint b;
    } cdiv_cfg_t;

    // Number of set bits in a non-negative value.
    function automatic int popcnt(input longint v);
        int c;
        c = 0;
        for (int i = 0; i < 63; i++) begin
            if (v[i]) c++;
        end
        return c;
    endfunction

    // Smallest value with the fewest set bits inside [lo, hi].
    function automatic longint sparse_pick(input longint lo, input longint hi);
        longint pre;
        int     top;
        if (lo == 0) return 0;
        if (lo == hi) return lo;
        top = 0;
        for (int i = 0; i < 63; i++) begin
            if (lo[i] != hi[i]) top = i;
        end
        pre = hi & ~((longint'(1) << (top + 1)) - 1);
        if (pre == lo) return pre;
        for (int j = 0; j <= top; j++) begin
            if ((pre | (longint'(1) << j)) >= lo) return pre | (longint'(1) << j);
        end
        return hi;
    endfunction

    // Range of addends that keeps every operand correct for a given K and A.
    // Operand x is split as x = q*d + r; the error term is q*e + a*r.
    function automatic b_span_t addend_span(input int n, input int d,
                                            input rnd_mode_t mode,
                                            input int k, input longint a);
        b_span_t s;
        longint two_k, e, h, m, qq, rq, r0;
        longint v0r, vq0, vqr, vpr, mn, mx, hi0, hi1, lim0, lim1;
        two_k = longint'(1) << k;
        e     = a * d - two_k;
        h     = (mode == RND_NEAREST) ? longint'((d - 1) / 2) : 0;
        m     = (longint'(1) << n) - 1 + h;
        qq    = m / d;
        rq    = m % d;
        r0    = (longint'(d - 1) < m) ? longint'(d - 1) : m;
        v0r   = a * r0;
        vq0   = qq * e;
        vqr   = qq * e + a * rq;
        vpr   = (qq > 0) ? (qq - 1) * e + a * (d - 1) : 0;
        mn = 0;
        if (v0r < mn) mn = v0r;
        if (vq0 < mn) mn = vq0;
        if (vqr < mn) mn = vqr;
        if (vpr < mn) mn = vpr;
        mx = 0;
        if (v0r > mx) mx = v0r;
        if (vq0 > mx) mx = vq0;
        if (vqr > mx) mx = vqr;
        if (vpr > mx) mx = vpr;
        s.lo = a * h - mn;
        if (s.lo < 0) s.lo = 0;
        if (mode == RND_FAITHFUL) begin
            hi0 = (vq0 > 0) ? vq0 : 0;
            hi1 = v0r;
            if (vqr > hi1) hi1 = vqr;
            if (vpr > hi1) hi1 = vpr;
            lim0 = two_k - 1 - hi0;
            lim1 = 2 * two_k - 1 - hi1;
            s.hi = (lim0 < lim1) ? lim0 : lim1;
        end else begin
            s.hi = two_k - 1 - mx + a * h;
        end
        s.ok = (s.lo <= s.hi);
        return s;
    endfunction

    // Smallest K with a valid multiplier; sparsest addend on ties.
    function automatic cdiv_cfg_t derive_cfg(input int n, input int d,
                                             input rnd_mode_t mode);
        cdiv_cfg_t c;
        b_span_t   sc, sf;
        longint    af, bc, bf;
        c.k = 0;
        c.a = 1;
        c.b = 0;
        for (int k = 1; k < 62; k++) begin
            af = (longint'(1) << k) / d;
            sc = addend_span(n, d, mode, k, af + 1);
            if (af >= 1) sf = addend_span(n, d, mode, k, af);
            else begin
                sf.ok = 1'b0;
                sf.lo = 0;
                sf.hi = 0;
            end
            if (sc.ok || sf.ok) begin
                bc = sparse_pick(sc.lo, sc.hi);
                bf = sparse_pick(sf.lo, sf.hi);
                c.k = k;
                if (sc.ok && (!sf.ok || popcnt(bc) <= popcnt(bf))) begin
                    c.a = af + 1;
                    c.b = bc;
                end else begin
                    c.a = af;
                    c.b = bf;
                end
                return c;
            end
        end
        return c;
    endfunction

    // Largest quotient the mode can return for an n-bit operand.
    function automatic longint quot_max(input int n, input int d,
                                        input rnd_mode_t mode);
        longint m;
        m = (longint'(1) << n) - 1;
        case (mode)
            RND_NEAREST:  return (2 * m + d) / (2 * d);
            RND_FAITHFUL: return (m + d - 1) / d;
            default:      return m / d;
        endcase
    endfunction

    // Quotient port width.
    function automatic int quot_width(input int n, input int d,
                                      input rnd_mode_t mode);
        longint qm;
        qm = quot_max(n, d, mode);
        return (qm > 0) ? $clog2(qm + 1) : 1;
    endfunction

endpackage

// File: rtl/cdiv_mul_add.sv
// Multiply-add datapath: sum = A*x + B, then the shift by K is pure wiring.
// Assumes PW = N + K + 1 so the sum never wraps; flags any set bit above
// the quotient field so the caller can check the port width.
module cdiv_mul_add #(
    parameter int N  = 12,
    parameter int K  = 4,
    parameter int PW = 17,
    parameter int QW = 10,
    parameter logic [PW-1:0] A_C = '0,
    parameter logic [PW-1:0] B_C = '0
) (
    input  logic [N-1:0]  x_i,
    output logic [QW-1:0] q_o,
    output logic          spill_o
);

    logic [PW-1:0] sum;
    logic [PW-1:0] shifted;

    // Product of the operand and the multiplier, plus the addend.
    always_comb begin
        sum     = A_C * PW'(x_i) + B_C;
        shifted = sum >> K;
    end

    // Split the shifted sum into the quotient and the spill flag.
    always_comb begin
        q_o     = shifted[QW-1:0];
        spill_o = |shifted[PW-1:QW];
    end

endmodule

// File: rtl/cdiv_out_reg.sv
// Quotient register with synchronous active-low reset to zero.
module cdiv_out_reg #(
    parameter int QW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [QW-1:0] d_i,
    output logic [QW-1:0] q_o
);

    // Capture the quotient each clock, clear it while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end

endmodule

// File: rtl/cdiv_const.sv
// Top: unsigned division by the constant D via (A*x + B) >> K.
// Constants are derived at elaboration from N, D and MODE. D must be odd, >= 3.
// OUT_REG selects a registered or a combinational quotient.
module cdiv_const #(
    parameter int N = 12,
    parameter int D = 7,
    parameter cdiv_pkg::rnd_mode_t MODE = cdiv_pkg::RND_TRUNC,
    parameter bit OUT_REG = 1'b1,
    localparam int QW = cdiv_pkg::quot_width(N, D, MODE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  x_i,
    output logic [QW-1:0] q_o
);

    localparam cdiv_pkg::cdiv_cfg_t CFG = cdiv_pkg::derive_cfg(N, D, MODE);
    localparam int K  = CFG.k;
    localparam int PW = N + K + 1;
    localparam logic [PW-1:0] A_C = PW'(CFG.a);
    localparam logic [PW-1:0] B_C = PW'(CFG.b);

    logic [QW-1:0] q_comb;
    logic          spill;

    cdiv_mul_add #(
        .N(N), .K(K), .PW(PW), .QW(QW), .A_C(A_C), .B_C(B_C)
    ) u_dp (
        .x_i    (x_i),
        .q_o    (q_comb),
        .spill_o(spill)
    );

    generate
        if (OUT_REG) begin : g_reg
            cdiv_out_reg #(.QW(QW)) u_reg (
                .clk  (clk),
                .rst_n(rst_n),
                .d_i  (q_comb),
                .q_o  (q_o)
            );
        end else begin : g_comb
            assign q_o = q_comb;
        end
    endgenerate

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spill);

    // R5
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i == '0) |-> (q_comb == '0));

    // R4
    exact_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((longint'(x_i) % D) == 0) |-> (longint'(q_comb) * D == longint'(x_i)));

    generate
        if (MODE == cdiv_pkg::RND_TRUNC) begin : g_chk_trunc
            // R1
            trunc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (longint'(q_comb) * D <= longint'(x_i)) &&
                (longint'(x_i) < longint'(q_comb) * D + D));
        end else if (MODE == cdiv_pkg::RND_NEAREST) begin : g_chk_near
            // R2
            nearest_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (2 * longint'(q_comb) * D - 2 * longint'(x_i) < D) &&
                (2 * longint'(x_i) - 2 * longint'(q_comb) * D < D));
        end else begin : g_chk_faith
            // R3
            faithful_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (longint'(q_comb) * D - longint'(x_i) < D) &&
                (longint'(x_i) - longint'(q_comb) * D < D));
        end
    endgenerate

endmodule

// File: tb/sim_cdiv_const.sv
// Bench: full operand sweep over five configurations, reference quotient by
// integer division, one-clock latency and mid-run reset of registered ones.
module sim_cdiv_const;

    logic clk = 1'b0;
    logic rst_n;
    int   xv;
    int   compared = 0;
    int   mismatched = 0;
    bit   rst_flag = 1'b0;
    int   pend[$];

    always #4 clk = ~clk;

    logic [11:0] x0;
    logic [7:0]  x1, x2, x3;
    logic [9:0]  x4;
    // Widths from the largest quotient of each mode (R5).
    logic [9:0]  q0;   // floor(4095/7)=585
    logic [6:0]  q1;   // nearest 255/3 -> 85
    logic [4:0]  q2;   // ceil(255/11)=24
    logic [3:0]  q3;   // floor(255/25)=10
    logic [6:0]  q4;   // nearest 1023/13 -> 79

    assign x0 = xv[11:0];
    assign x1 = xv[7:0];
    assign x2 = xv[7:0];
    assign x3 = xv[7:0];
    assign x4 = xv[9:0];

    cdiv_const u0 (.clk(clk), .rst_n(rst_n), .x_i(x0), .q_o(q0));
    cdiv_const #(.N(8), .D(3), .MODE(cdiv_pkg::RND_NEAREST), .OUT_REG(1'b1))
        u1 (.clk(clk), .rst_n(rst_n), .x_i(x1), .q_o(q1));
    cdiv_const #(.N(8), .D(11), .MODE(cdiv_pkg::RND_FAITHFUL), .OUT_REG(1'b1))
        u2 (.clk(clk), .rst_n(rst_n), .x_i(x2), .q_o(q2));
    cdiv_const #(.N(8), .D(25), .MODE(cdiv_pkg::RND_TRUNC), .OUT_REG(1'b0))
        u3 (.clk(clk), .rst_n(rst_n), .x_i(x3), .q_o(q3));
    cdiv_const #(.N(10), .D(13), .MODE(cdiv_pkg::RND_NEAREST), .OUT_REG(1'b0))
        u4 (.clk(clk), .rst_n(rst_n), .x_i(x4), .q_o(q4));

    // Compare one quotient against the reference for its mode.
    task automatic judge(input string inst, input int mode, input int d,
                         input int x, input int xmax, input int got);
        int    fl, ex;
        bit    ok;
        string tag;
        fl = x / d;
        ex = (mode == 1) ? (2 * x + d) / (2 * d) : fl;
        ok = (got == ex) || (mode == 2 && (x % d) != 0 && got == fl + 1);
        if (x == 0 || x == xmax) tag = "R5";
        else if (x % d == 0)     tag = "R4";
        else if (mode == 0)      tag = "R1";
        else if (mode == 1)      tag = "R2";
        else                     tag = "R3";
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s x=%0d actual=%0d expected=%0d", tag, inst, x, got, ex);
        end
    endtask

    // Generic equality check.
    task automatic check_eq(input string tag, input string what,
                            input int got, input int ex);
        compared++;
        if (got != ex) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, ex);
        end
    endtask

    initial begin
        int xp;
        rst_n = 1'b0;
        xv    = 0;
        repeat (3) @(negedge clk);
        check_eq("R6", "u0 reset", int'(q0), 0);
        check_eq("R6", "u1 reset", int'(q1), 0);
        check_eq("R6", "u2 reset", int'(q2), 0);
        rst_n = 1'b1;
        pend.push_back(xv);
        for (int i = 1; i <= 4100; i++) begin
            @(negedge clk);
            xp = pend.pop_front();
            if (rst_flag) begin
                check_eq("R6", "u0 mid reset", int'(q0), 0);
                check_eq("R6", "u1 mid reset", int'(q1), 0);
                check_eq("R6", "u2 mid reset", int'(q2), 0);
                rst_flag = 1'b0;
                rst_n    = 1'b1;
            end else begin
                judge("u0", 0, 7, xp % 4096, 4095, int'(q0));
                judge("u1", 1, 3, xp % 256, 255, int'(q1));
                judge("u2", 2, 11, xp % 256, 255, int'(q2));
            end
            judge("u3", 0, 25, xp % 256, 255, int'(q3));
            judge("u4", 1, 13, xp % 1024, 1023, int'(q4));
            if (i == 2001) begin
                rst_n    = 1'b0;
                rst_flag = 1'b1;
            end
            xv = i % 4096;
            pend.push_back(xv);
            // R6: registered output holds the previous quotient until the edge.
            if (!rst_flag && (i % 64) == 5) begin
                #1;
                check_eq("R6", "u0 latency", int'(q0), (xp % 4096) / 7);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule